// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART's serial bit lines and an infrared transceiver. It runs on the UART's 16x bit clock, and a clock-enable input qualifies every edge it acts on. On the transmit side, a logic-0 bit becomes a narrow positive pulse centred in its 16-clock bit cell. A logic-1 bit sends nothing.

On the receive side, the infrared input first passes through a two-flop synchroniser. Each falling edge seen after that is stretched into a low level exactly 16 clocks long on the internal receive line. The UART can then sample that line as an ordinary serial bit stream. Only falling edges are detected, so the block decodes pulses of either polarity without a setting. A positive pulse is decoded on its trailing edge and a negative pulse on its leading edge.

A receive-enable input turns the decoder off by forcing the receive line idle. Bit sampling inside the UART is not part of this block.

Top module: `ir_sir_codec`

## Requirements
- R1: While reset (`rst_n` low, sampled at the clock) is active, and after it, `ir_tx` is 0 and `rx_bit` is 1.
- R2: On every enabled edge with `tx_bit` = 1, `ir_tx` goes to 0 and the pulse-position count is cleared. The next 0 cell therefore starts counting from its first clock.
- R3: For consecutive enabled edges with `tx_bit` = 0, numbered 1, 2, 3 and so on, `ir_tx` is 1 exactly after edges whose number modulo 16 is 7, 8 or 9. This gives a 3-clock pulse in every 16-clock cell, repeated for back-to-back 0 bits.
- R4: `ir_rx` is sampled at enabled edges. If it is sampled high at edge n-1 and low at edge n, `rx_bit` goes to 0 after enabled edge n+2. It stays 0 for exactly 16 enabled edges and returns to 1 after edge n+18.
- R5: With no high-to-low transition on `ir_rx`, `rx_bit` stays 1. This holds for a steady high, a steady low and a rising edge.
- R6: A falling edge that would be acted on during the first 15 clocks of a low window is ignored. The window still ends 16 clocks after it began.
- R7: A falling edge that would be acted on at the edge ending a window keeps `rx_bit` low without a gap and starts a fresh 16-clock window. An edge one clock later leaves exactly one clock of 1 between the two windows.
- R8: A positive pulse (low-high-low) is decoded from its trailing edge, and a negative pulse (high-low-high) from its leading edge.
- R9: On an enabled edge with `rx_en` = 0, `rx_bit` goes to 1 and the window count is cleared. A falling edge acted on later produces a full 16-clock window.
- R10: On an edge with `clk_en` = 0, neither output nor any internal state changes, and `ir_rx` is not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16x bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Qualifies the clock edges the block acts on |
| tx_bit | input | 1 | Serial transmit bit from the UART (1 = idle/mark) |
| ir_tx | output | 1 | Infrared transmit pulse, active high |
| ir_rx | input | 1 | Infrared receive input, asynchronous |
| rx_en | input | 1 | Receive enable; 0 forces `rx_bit` high |
| rx_bit | output | 1 | Decoded serial receive bit to the UART |

## Verification
The bench goes after the window boundary. A follow-up edge arriving exactly 16 clocks after the first is one a design with a plain ignore-while-busy rule would drop, losing a 0 bit. An edge 17 clocks later must leave a single-clock high. A stretcher with an off-by-one count would show a window of 15 or 17 clocks.

The bench also tests:
- Back-to-back 0 cells and a 0 cell following a 1. A pulse counter that is not cleared or does not wrap would misplace the pulse.
- Steady-low and rising-edge inputs. A level- or rise-sensitive detector would emit spurious 0s.
- Receive-enable dropping mid-window, where a design that does not clear the count would shorten the next window.
- Clock-enable gaps, where a design that samples `ir_rx` or counts during the gap drifts from the model.

// File: rtl/sir_codec_pkg.sv
// Package: shared constants for the infrared SIR pulse codec.
// Assumes a 16x oversampling clock, which fixes the default cell length.
package sir_codec_pkg;
    localparam int unsigned DEF_CELL_CLKS   = 16;
    localparam int unsigned DEF_PULSE_FIRST = 7;
    localparam int unsigned DEF_PULSE_LAST  = 9;
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/sir_sync.sv
// Module: sir_sync
// Multi-flop synchroniser for one asynchronous input bit, advanced only on
// enabled edges. Assumes the idle level of the line is high, so every stage
// resets to 1.
module sir_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n)      stage_q[0] <= 1'b1;
                    else if (clk_en) stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Pass the value down the chain one stage per enabled edge.
                always_ff @(posedge clk) begin
                    if (!rst_n)      stage_q[g] <= 1'b1;
                    else if (clk_en) stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/sir_tx_pulse.sv
// Module: sir_tx_pulse
// Turns each 0 bit into a positive pulse. The pulse covers clocks
// PULSE_FIRST..PULSE_LAST of each CELL_CLKS-clock cell. A 1 bit holds the
// output low and clears the cell counter. Assumes the UART changes tx_bit on
// cell boundaries.
module sir_tx_pulse #(
    parameter int unsigned CELL_CLKS   = 16,
    parameter int unsigned PULSE_FIRST = 7,
    parameter int unsigned PULSE_LAST  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic tx_bit,
    output logic ir_tx
);
    localparam int unsigned CW = $clog2(CELL_CLKS);
    localparam logic [CW-1:0] CNT_LAST  = CW'(CELL_CLKS - 1);
    localparam logic [CW-1:0] POS_FIRST = CW'(PULSE_FIRST);
    localparam logic [CW-1:0] POS_LAST  = CW'(PULSE_LAST);

    logic [CW-1:0] cell_cnt;
    logic [CW-1:0] cnt_nxt;

    // Next position in the cell, wrapping at the cell length.
    always_comb begin
        cnt_nxt = (cell_cnt == CNT_LAST) ? '0 : cell_cnt + 1'b1;
    end

    // Advance the cell position and register the pulse window decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_cnt <= '0;
            ir_tx    <= 1'b0;
        end else if (clk_en) begin
            if (tx_bit) begin
                cell_cnt <= '0;
                ir_tx    <= 1'b0;
            end else begin
                cell_cnt <= cnt_nxt;
                ir_tx    <= (cnt_nxt >= POS_FIRST) && (cnt_nxt <= POS_LAST);
            end
        end
    end
endmodule

// File: rtl/sir_rx_stretch.sv
// Module: sir_rx_stretch
// Turns each falling edge of the synchronised receive line into a
// CELL_CLKS-clock low window. Edges inside a window are ignored, except at
// its final clock, where they restart it. Assumes rx_sync is already
// synchronous to clk.
module sir_rx_stretch #(
    parameter int unsigned CELL_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic rx_en,
    input  logic rx_sync,
    output logic rx_bit
);
    localparam int unsigned CW = $clog2(CELL_CLKS);
    localparam logic [CW-1:0] WIN_LAST = CW'(CELL_CLKS - 1);

    logic          prev_q;
    logic          fall;
    logic          win_on;
    logic [CW-1:0] win_cnt;

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b1;
        else if (clk_en) prev_q <= rx_sync;
    end

    // A high-to-low transition of the synchronised line.
    always_comb begin
        fall = prev_q & ~rx_sync;
    end

    // Open, count, retrigger or close the low window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_on  <= 1'b0;
            win_cnt <= '0;
        end else if (clk_en) begin
            if (!rx_en) begin
                win_on  <= 1'b0;
                win_cnt <= '0;
            end else if (win_on) begin
                if (win_cnt == WIN_LAST) begin
                    win_on  <= fall;
                    win_cnt <= '0;
                end else begin
                    win_cnt <= win_cnt + 1'b1;
                end
            end else if (fall) begin
                win_on  <= 1'b1;
                win_cnt <= '0;
            end
        end
    end

    assign rx_bit = ~win_on;
endmodule

// File: rtl/ir_sir_codec.sv
// Module: ir_sir_codec (top)
// Infrared SIR encoder and decoder between a UART bit stream and an IR
// transceiver. All state advances only on edges with clk_en high. Reset is
// synchronous and active low.
module ir_sir_codec #(
    parameter int unsigned CELL_CLKS   = sir_codec_pkg::DEF_CELL_CLKS,
    parameter int unsigned PULSE_FIRST = sir_codec_pkg::DEF_PULSE_FIRST,
    parameter int unsigned PULSE_LAST  = sir_codec_pkg::DEF_PULSE_LAST,
    parameter int unsigned SYNC_STAGES = sir_codec_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic tx_bit,
    output logic ir_tx,
    input  logic ir_rx,
    input  logic rx_en,
    output logic rx_bit
);
    logic rx_sync;

    sir_tx_pulse #(
        .CELL_CLKS  (CELL_CLKS),
        .PULSE_FIRST(PULSE_FIRST),
        .PULSE_LAST (PULSE_LAST)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .clk_en(clk_en),
        .tx_bit(tx_bit),
        .ir_tx (ir_tx)
    );

    sir_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .d_async(ir_rx),
        .q_sync (rx_sync)
    );

    sir_rx_stretch #(
        .CELL_CLKS(CELL_CLKS)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .rx_en  (rx_en),
        .rx_sync(rx_sync),
        .rx_bit (rx_bit)
    );
endmodule

// File: rtl/ir_sir_codec_chk.sv
// Module: ir_sir_codec_chk
// Port-level properties of the codec, bound to every ir_sir_codec instance.
module ir_sir_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic tx_bit,
    input logic ir_tx,
    input logic rx_en,
    input logic rx_bit
);
    int unsigned hi_run;

    // Length of the current run of high ir_tx.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_run <= 0;
        else if (ir_tx) hi_run <= (hi_run < 100) ? hi_run + 1 : hi_run;
        else            hi_run <= 0;
    end

    // R2
    tx_one_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && tx_bit) |=> !ir_tx);

    // R3
    tx_pulse_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_tx) |-> $past(!tx_bit));

    // R3
    tx_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= 3);

    // R9
    rx_disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !rx_en) |=> rx_bit);

    // R5
    rx_low_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_bit) |-> $past(rx_en));

    // R10
    hold_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(ir_tx) && $stable(rx_bit)));
endmodule

bind ir_sir_codec ir_sir_codec_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clk_en(clk_en),
    .tx_bit(tx_bit),
    .ir_tx (ir_tx),
    .rx_en (rx_en),
    .rx_bit(rx_bit)
);

// File: tb/ir_sir_codec_tb_top.sv
// Bench: behavioural reference model of the codec, compared on every clock.
module ir_sir_codec_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n, clk_en, tx_bit, ir_rx, rx_en;
    logic ir_tx, rx_bit;

    int vectors = 0;
    int misses  = 0;
    string tag = "R1";

    // Reference model state.
    int  zero_edges;
    bit  m_tx, m_rx;
    bit  hist[$];
    int  low_left;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_sir_codec dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clk_en(clk_en),
        .tx_bit(tx_bit),
        .ir_tx (ir_tx),
        .ir_rx (ir_rx),
        .rx_en (rx_en),
        .rx_bit(rx_bit)
    );

    task automatic model_reset();
        zero_edges = 0;
        m_tx = 0;
        m_rx = 1;
        low_left = 0;
        hist = {1'b1, 1'b1, 1'b1};
    endtask

    // Advance the model by one clock edge using the driven inputs.
    task automatic model_step();
        bit det;
        if (!rst_n) begin
            model_reset();
            return;
        end
        if (!clk_en) return;
        // Transmit: pulse on zero-cell clock numbers 7..9 modulo 16.
        if (tx_bit) begin
            zero_edges = 0;
            m_tx = 0;
        end else begin
            zero_edges++;
            m_tx = ((zero_edges % 16) >= 7) && ((zero_edges % 16) <= 9);
        end
        // Receive: hist[0] is the newest sample; a fall seen two samples back
        // is acted on now.
        det = hist[2] && !hist[1];
        hist.push_front(ir_rx);
        void'(hist.pop_back());
        if (!rx_en) begin
            m_rx = 1;
            low_left = 0;
        end else if (low_left > 0) begin
            low_left--;
            if (low_left == 0) begin
                if (det) low_left = 16;
                else     m_rx = 1;
            end
        end else if (det) begin
            low_left = 16;
            m_rx = 0;
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at negedge.
    task automatic tick(input bit t, input bit r, input bit en = 1'b1,
                        input bit ce = 1'b1);
        tx_bit = t;
        ir_rx  = r;
        rx_en  = en;
        clk_en = ce;
        @(posedge clk);
        model_step();
        @(negedge clk);
        vectors++;
        if (ir_tx !== m_tx || rx_bit !== m_rx) begin
            misses++;
            $display("FAIL %s t=%0t ir_tx=%b exp %b rx_bit=%b exp %b",
                     tag, $time, ir_tx, m_tx, rx_bit, m_rx);
        end
    endtask

    task automatic rx_ticks(input bit r, input int n, input bit en = 1'b1);
        for (int i = 0; i < n; i++) tick(1'b1, r, en);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 20000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        model_reset();
        rst_n = 1'b0;
        tx_bit = 1'b1; ir_rx = 1'b1; rx_en = 1'b1; clk_en = 1'b1;
        @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
        rst_n = 1'b1;

        tag = "R2";
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b1);
        tag = "R3";
        for (int i = 0; i < 40; i++) tick(1'b0, 1'b1);
        tag = "R2";
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b1);
        tag = "R3";
        for (int i = 0; i < 36; i++) tick(1'b0, 1'b1);
        tick(1'b1, 1'b1);

        tag = "R5";
        rx_ticks(1'b1, 20);
        rx_ticks(1'b0, 4);
        for (int i = 0; i < 30; i++) tick(1'b1, 1'b0);
        rx_ticks(1'b1, 20);

        tag = "R4";
        rx_ticks(1'b0, 40);
        rx_ticks(1'b1, 25);

        tag = "R8";
        rx_ticks(1'b0, 20);
        rx_ticks(1'b1, 3);
        rx_ticks(1'b0, 25);
        rx_ticks(1'b1, 10);
        rx_ticks(1'b0, 3);
        rx_ticks(1'b1, 25);

        tag = "R6";
        rx_ticks(1'b0, 2);
        rx_ticks(1'b1, 4);
        rx_ticks(1'b0, 2);
        rx_ticks(1'b1, 3);
        rx_ticks(1'b0, 2);
        rx_ticks(1'b1, 25);

        tag = "R7";
        for (int k = 0; k < 3; k++) begin
            rx_ticks(1'b0, 3);
            rx_ticks(1'b1, 13);
        end
        rx_ticks(1'b1, 20);
        for (int k = 0; k < 3; k++) begin
            rx_ticks(1'b0, 3);
            rx_ticks(1'b1, 14);
        end
        rx_ticks(1'b1, 20);

        tag = "R9";
        rx_ticks(1'b0, 3);
        rx_ticks(1'b1, 4);
        rx_ticks(1'b1, 5, 1'b0);
        rx_ticks(1'b0, 3, 1'b0);
        rx_ticks(1'b1, 5, 1'b0);
        rx_ticks(1'b1, 5);
        rx_ticks(1'b0, 3);
        rx_ticks(1'b1, 25);

        tag = "R10";
        rx_ticks(1'b0, 3);
        rx_ticks(1'b1, 3);
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b1, 1'b0);
        rx_ticks(1'b1, 25);
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b1);
        tick(1'b1, 1'b1);

        tag = "R1";
        rst_n = 1'b0;
        tick(1'b0, 1'b0);
        rst_n = 1'b1;
        rx_ticks(1'b1, 5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule